// File: doc/BRIEF.md
# Stream Identifier Filter Matcher

This block sits beside a bank of event counters and decides, for every monitored transaction, which counters may count it. Each counter owns a filter word and a span flag. With the span flag clear, a transaction passes only when its stream identifier equals the filter word on every bit. With the span flag set, the filter word carries its own mask: the lowest zero bit of the word, together with every bit below it, is treated as don't-care, and the remaining upper bits must equal the identifier. A filter word of all ones with the span flag set therefore passes every identifier, which is also the state after reset.

A global-mode input makes counter 0's filter word and span flag govern all counters at once, so the per-counter settings of counters 1 and up stop mattering while it is high and take effect again when it drops. Configuration arrives on one write port that carries a counter index, a register-kind select and a 32-bit data word; a type-register write takes the span flag from bit 29 of the data word. Results leave as a per-counter match vector, registered one cycle after the transaction strobe. A two-state output machine controls presentation: `ST_IDLE` (no result shown) and `ST_SHOW` (result shown). The transitions are `ST_IDLE -> ST_SHOW` and `ST_SHOW -> ST_SHOW` when `txn_vld` is high, and `ST_SHOW -> ST_IDLE` and `ST_IDLE -> ST_IDLE` when it is low.

Top module: `sidf_matcher`

## Requirements
- R1: After reset every filter word is all ones and every span flag is 1, so every counter's match bit is 1 for any identifier until a write occurs.
- R2: With span flag 0, a counter's match bit is 1 exactly when the identifier equals its filter word on all SID_W bits.
- R3: With span flag 1, the lowest zero bit of the filter word and all bits beneath it are ignored and every higher bit must equal the identifier; filter 0x42 passes 0x42 and 0x43 only, filter 0x47 passes 0x40 through 0x4F only, filter 0 passes 0 and 1 only.
- R4: A filter word with no zero bit, with span flag 1, passes every identifier.
- R5: A write with `cfg_is_type`=0 loads the filter word from `cfg_wdata[SID_W-1:0]`; a write with `cfg_is_type`=1 loads the span flag from `cfg_wdata[29]`, and the other bits of that word have no effect on matching.
- R6: While `global_mode` is 1, every counter's match bit uses counter 0's filter word and span flag, so all bits of a result are equal; counters 1 and up resume their own settings once it is 0.
- R7: `match_vld` is 1 in the cycle after each cycle in which `txn_vld` is 1 and 0 otherwise; back-to-back transactions give back-to-back results in order.
- R8: `match_vec` is all zeros whenever `match_vld` is 0.
- R9: A write changes only the addressed counter and applies to transactions presented in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ctr | input | IDX_W | Counter index of the write |
| cfg_is_type | input | 1 | 1: type register (span flag at bit 29), 0: filter word |
| cfg_wdata | input | 32 | Write data |
| global_mode | input | 1 | 1: counter 0's filter governs all counters |
| txn_vld | input | 1 | Transaction strobe |
| txn_sid | input | SID_W | Stream identifier of the transaction |
| match_vld | output | 1 | Result valid, one cycle after `txn_vld` |
| match_vec | output | NUM_CTR | Per-counter pass bits, zero when not valid |

## Verification
The bench builds the block with its defaults: four counters and 32-bit identifiers. Four counters leave three lanes whose own settings can disagree with counter 0, which makes the global override visible as an all-equal vector, and the full 32-bit width puts the span flag at bit 29 inside the filter range and lets an all-ones word exercise the carry out of the top bit. A scoreboard model, written from the requirements with a bit-by-bit search for the lowest zero, predicts each vector.

// File: rtl/sidf_pkg.sv
package sidf_pkg;

    // Width of the configuration data word and the bit holding the span flag
    localparam int CFG_W    = 32;
    localparam int SPAN_POS = 29;

    // Output presentation states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } sidf_state_e;

endpackage

// File: rtl/sidf_cfg_bank.sv
module sidf_cfg_bank
    import sidf_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int SID_W   = 32,
    localparam int IDX_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [IDX_W-1:0]                cfg_ctr,
    input  logic                            cfg_is_type,
    input  logic [CFG_W-1:0]                cfg_wdata,
    output logic [NUM_CTR-1:0][SID_W-1:0]   flt_o,
    output logic [NUM_CTR-1:0]              span_o
);

    for (genvar c = 0; c < NUM_CTR; c++) begin : g_ctr
        logic             sel;
        logic [SID_W-1:0] flt_r;
        logic             span_r;

        assign sel = cfg_we && (cfg_ctr == IDX_W'(c));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flt_r  <= '1;
                span_r <= 1'b1;
            end else if (sel) begin
                if (cfg_is_type) begin
                    span_r <= cfg_wdata[SPAN_POS];
                end else begin
                    flt_r  <= cfg_wdata[SID_W-1:0];
                end
            end
        end

        assign flt_o[c]  = flt_r;
        assign span_o[c] = span_r;
    end

endmodule

// File: rtl/sidf_lane.sv
module sidf_lane #(
    parameter int SID_W = 32
) (
    input  logic [SID_W-1:0] flt,
    input  logic             span,
    input  logic [SID_W-1:0] sid,
    output logic             hit
);

    logic [SID_W-1:0] bumped;
    logic [SID_W-1:0] ign;
    logic [SID_W-1:0] care;

    // Adding one flips the trailing ones and the lowest zero; the XOR marks
    // exactly those bits. An all-ones word wraps to zero, marking every bit.
    assign bumped = flt + SID_W'(1);
    assign ign    = flt ^ bumped;
    assign care   = span ? ~ign : '1;
    assign hit    = (((sid ^ flt) & care) == '0);

endmodule

// File: rtl/sidf_matcher.sv
module sidf_matcher
    import sidf_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int SID_W   = 32,
    localparam int IDX_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_ctr,
    input  logic               cfg_is_type,
    input  logic [31:0]        cfg_wdata,
    input  logic               global_mode,
    input  logic               txn_vld,
    input  logic [SID_W-1:0]   txn_sid,
    output logic               match_vld,
    output logic [NUM_CTR-1:0] match_vec
);

    logic [NUM_CTR-1:0][SID_W-1:0] flt;
    logic [NUM_CTR-1:0]            span;
    logic [NUM_CTR-1:0]            hit_d;
    logic [NUM_CTR-1:0]            hit_q;
    sidf_state_e                   state_q;
    sidf_state_e                   state_d;

    sidf_cfg_bank #(
        .NUM_CTR (NUM_CTR),
        .SID_W   (SID_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_ctr     (cfg_ctr),
        .cfg_is_type (cfg_is_type),
        .cfg_wdata   (cfg_wdata),
        .flt_o       (flt),
        .span_o      (span)
    );

    for (genvar c = 0; c < NUM_CTR; c++) begin : g_lane
        logic [SID_W-1:0] use_flt;
        logic             use_span;

        assign use_flt  = global_mode ? flt[0]  : flt[c];
        assign use_span = global_mode ? span[0] : span[c];

        sidf_lane #(
            .SID_W (SID_W)
        ) u_lane (
            .flt  (use_flt),
            .span (use_span),
            .sid  (txn_sid),
            .hit  (hit_d[c])
        );
    end

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = txn_vld ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = txn_vld ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hit_q   <= '0;
        end else begin
            state_q <= state_d;
            if (txn_vld) begin
                hit_q <= hit_d;
            end
        end
    end

    // Outputs
    always_comb begin
        match_vld = (state_q == ST_SHOW);
        match_vec = match_vld ? hit_q : '0;
    end

endmodule

// File: rtl/sidf_matcher_chk.sv
module sidf_matcher_chk #(
    parameter int NUM_CTR = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic               global_mode,
    input logic               txn_vld,
    input logic               match_vld,
    input logic [NUM_CTR-1:0] match_vec
);

    logic wr_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_seen <= 1'b0;
        end else if (cfg_we) begin
            wr_seen <= 1'b1;
        end
    end

    a_r7_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        txn_vld |=> match_vld);

    a_r7_no_stray_result: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_vld |=> !match_vld);

    a_r8_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !match_vld |-> (match_vec == '0));

    a_r6_global_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_vld && global_mode) |=> (match_vec == '0 || (&match_vec)));

    a_r1_open_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vld && !wr_seen) |-> (&match_vec));

endmodule

bind sidf_matcher sidf_matcher_chk #(
    .NUM_CTR (NUM_CTR)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .global_mode (global_mode),
    .txn_vld     (txn_vld),
    .match_vld   (match_vld),
    .match_vec   (match_vec)
);

// File: tb/test_sidf_matcher.sv
module test_sidf_matcher;

    localparam int NC = 4;
    localparam int SW = 32;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_ctr = '0;
    logic          cfg_is_type = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic          global_mode = 1'b0;
    logic          txn_vld = 1'b0;
    logic [SW-1:0] txn_sid = '0;
    logic          match_vld;
    logic [NC-1:0] match_vec;

    always #5 clk = ~clk;

    sidf_matcher #(.NUM_CTR(NC), .SID_W(SW)) i_sidf_matcher (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ctr(cfg_ctr),
        .cfg_is_type(cfg_is_type), .cfg_wdata(cfg_wdata),
        .global_mode(global_mode), .txn_vld(txn_vld), .txn_sid(txn_sid),
        .match_vld(match_vld), .match_vec(match_vec)
    );

    // Reference model state
    logic [SW-1:0] m_flt [NC];
    logic          m_span [NC];
    logic          m_glob;

    logic [NC-1:0] exp_q [$];
    string         tag_q [$];
    int            n_chk = 0;
    int            n_bad = 0;
    logic          mon_on = 1'b0;

    function automatic logic lane_pass(logic [SW-1:0] f, logic s, logic [SW-1:0] id);
        int p;
        if (!s) return (id == f);
        p = -1;
        for (int b = 0; b < SW; b++) begin
            if (!f[b] && p < 0) p = b;
        end
        if (p < 0) return 1'b1;
        for (int b = p + 1; b < SW; b++) begin
            if (f[b] != id[b]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [NC-1:0] predict(logic [SW-1:0] id);
        logic [NC-1:0] v;
        for (int c = 0; c < NC; c++) begin
            int src;
            src = m_glob ? 0 : c;
            v[c] = lane_pass(m_flt[src], m_span[src], id);
        end
        return v;
    endfunction

    task automatic wr(input int ctr, input logic kind, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ctr = IW'(ctr); cfg_is_type = kind; cfg_wdata = data;
        if (kind) m_span[ctr] = data[29];
        else      m_flt[ctr]  = data[SW-1:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_glob(input logic g);
        @(negedge clk);
        global_mode = g;
        m_glob = g;
    endtask

    task automatic send(input logic [SW-1:0] id, input string tag);
        logic [NC-1:0] e;
        @(negedge clk);
        txn_vld = 1'b1;
        txn_sid = id;
        e = predict(id);
        #1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic gap();
        @(negedge clk);
        txn_vld = 1'b0;
    endtask

    // Monitor: compares results against the scoreboard queue
    always @(negedge clk) begin
        if (mon_on) begin
            if (match_vld) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R7 unexpected result: actual vec=%b expected no result", match_vec);
                end else begin
                    logic [NC-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (match_vec !== e) begin
                        n_bad++;
                        $display("FAIL %s: actual=%b expected=%b", t, match_vec, e);
                    end
                end
            end else begin
                n_chk++;
                if (exp_q.size() != 0) begin
                    n_bad++;
                    $display("FAIL R7 result missing for %s: actual vld=0 expected vld=1", tag_q[0]);
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
                n_chk++;
                if (match_vec !== '0) begin
                    n_bad++;
                    $display("FAIL R8 idle vector: actual=%b expected=%b", match_vec, {NC{1'b0}});
                end
            end
        end
    end

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) begin
            m_flt[c] = '1;
            m_span[c] = 1'b1;
        end
        m_glob = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);

        // R1: open after reset
        send(32'h0000_0000, "R1 reset id 0");
        send(32'hDEAD_BEEF, "R1 reset id DEADBEEF");
        send(32'hFFFF_FFFF, "R1 reset id all ones");
        gap();

        // R2 exact match on counter 1; R5 low type bits ignored
        wr(1, 1'b0, 32'h1234_5678);
        wr(1, 1'b1, 32'h0000_00FF);
        send(32'h1234_5678, "R2 exact equal");
        send(32'h1234_5679, "R2 exact low bit differs");
        send(32'h9234_5678, "R2 exact top bit differs");
        gap();
        // R9: only counter 1 changed
        send(32'h0BAD_F00D, "R9 other lanes untouched");
        gap();

        // R3 span patterns on counter 2
        wr(2, 1'b0, 32'h0000_0042);
        send(32'h0000_0042, "R3 0x42 passes 0x42");
        send(32'h0000_0043, "R3 0x42 passes 0x43");
        send(32'h0000_0041, "R3 0x42 rejects 0x41");
        send(32'h0000_0044, "R3 0x42 rejects 0x44");
        send(32'h0000_0142, "R3 0x42 rejects 0x142");
        gap();
        wr(2, 1'b0, 32'h0000_0047);
        send(32'h0000_0040, "R3 0x47 passes 0x40");
        send(32'h0000_004F, "R3 0x47 passes 0x4F");
        send(32'h0000_0050, "R3 0x47 rejects 0x50");
        send(32'h0000_003F, "R3 0x47 rejects 0x3F");
        gap();
        wr(3, 1'b0, 32'h0000_0000);
        send(32'h0000_0000, "R3 zero filter passes 0");
        send(32'h0000_0001, "R3 zero filter passes 1");
        send(32'h0000_0002, "R3 zero filter rejects 2");
        gap();

        // R4: all-ones filter with span restored on counter 1
        wr(1, 1'b1, 32'h2000_0000);
        wr(1, 1'b0, 32'hFFFF_FFFF);
        send(32'h5A5A_A5A5, "R4 all ones passes 5A5AA5A5");
        send(32'h8000_0000, "R4 all ones passes top bit");
        gap();

        // R5: span cleared by bit 29 alone even with other bits set
        wr(3, 1'b1, 32'hDFFF_FFFF);
        send(32'h0000_0000, "R5 span off exact 0");
        send(32'h0000_0001, "R5 span off rejects 1");
        gap();

        // R6: global mode with counter 0 exact 0x55
        wr(0, 1'b0, 32'h0000_0055);
        wr(0, 1'b1, 32'h0000_0000);
        set_glob(1'b1);
        send(32'h0000_0055, "R6 global pass 0x55");
        send(32'h0000_0044, "R6 global lanes ignore own filters");
        send(32'h0000_0000, "R6 global lanes ignore own filters 0");
        gap();
        set_glob(1'b0);
        send(32'h0000_0044, "R6 own filters resume");
        send(32'h0000_0055, "R6 own filters resume 0x55");
        gap();

        // R7: back-to-back stream
        send(32'h0000_0043, "R7 burst 1");
        send(32'h0000_0000, "R7 burst 2");
        send(32'h0000_0055, "R7 burst 3");
        send(32'h1234_5678, "R7 burst 4");
        gap();

        repeat (4) @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R7 leftover results: actual=%0d expected=0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule